// File: doc/BRIEF.md
# ECC-Protected Word RAM with Sub-Word Read-Modify-Write

This block holds a RAM of 39-bit stored words. Each word carries 32 data bits, six Hamming check bits and one overall parity bit. Every read is decoded. A single flipped bit anywhere in the stored word is repaired on the fly. Any pattern the code identifies as a double error is reported on the response and recorded in a sticky status flag, which software clears with a write-one strobe.

A full 32-bit store encodes the data and writes it in the cycle it is accepted. A byte or halfword store takes one extra cycle, and `req_ready` drops during that cycle. The block first reads the containing word, repairs it if needed, and merges the new lanes into it. It then writes the merged word back with freshly computed check bits. If the word it read holds an uncorrectable error, the store is dropped. Because of this, the array must be initialised with full-word stores after power-up.

Top module: `ecc_rmw_ram`

## Requirements
- R1: While and after reset, `rsp_valid`, `rsp_error` and `err_flag` are 0 and `req_ready` is 1.
- R2: A request accepted at clock edge n gives a response that is valid for exactly one cycle, after edge n+1. A read returns the stored data. A write returns `rsp_rdata` = 0 and no error. Size encoding: 0 = byte, 1 = halfword, 2 or 3 = full word.
- R3: A read of a word with one flipped bit returns the original data with no error and leaves `err_flag` clear. The stored layout is: data in bits 31:0, Hamming check bits in 37:32, overall parity in bit 38. The flipped bit may be a data bit, a check bit or the parity bit.
- R4: A read of a word with two flipped bits asserts `rsp_error` and sets `err_flag`.
- R5: `err_flag` stays set until a cycle in which `err_clr` is high. If a new uncorrectable error arrives in that same cycle, the flag stays set.
- R6: Byte and halfword stores take their data from `req_wdata` in lane position. Byte k occupies bits 8k+7:8k and is selected by address bits 1:0. A halfword uses lanes 0–1 or 2–3, selected by address bit 1. Only the addressed lanes change, and `req_ready` is 0 for the one cycle after such a store is accepted.
- R7: A sub-word store into a word with one flipped bit repairs that bit before merging, and writes back fresh check bits.
- R8: A sub-word store into a word with a double error asserts `rsp_error`, sets `err_flag` and leaves the stored word unchanged.
- R9: Reads and full-word stores are accepted on every cycle. A read accepted right after a store to the same word returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W+2 | Byte address |
| req_wdata | input | 32 | Store data, lane aligned |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Corrected load data |
| rsp_error | output | 1 | Uncorrectable error on this transfer |
| err_clr | input | 1 | Write-one strobe that clears err_flag |
| err_flag | output | 1 | Sticky uncorrectable-error status |

## Verification
On every cycle, the assertions check the handshake and timing rules. They confirm that a response follows each accepted request two edges later, and that `req_ready` drops only after a sub-word store. They also check that an error response always comes with a set status flag, that a clear without a coinciding error empties the flag, and that a double error never lets a merged word reach the array. Whether the data is right can only be shown by the bench's scenarios. This covers lane merging, repair of single flips in each field of the stored word, and the write-back of fresh check bits after a repaired sub-word store. It also covers the survival of a word whose sub-word store was cancelled.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DW  = 32;          // data bits per word
  localparam int HW  = 6;           // Hamming check bits
  localparam int CW  = DW + HW + 1; // stored word incl. overall parity
  localparam int NB  = DW / 8;      // byte lanes

  // Hamming position (1..CW-1, non power of two) of data bit idx
  function automatic logic [HW-1:0] data_pos(input int idx);
    int cnt;
    logic [HW-1:0] r;
    cnt = 0;
    r   = '0;
    for (int p = 1; p <= CW - 1; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) r = HW'(p);
        cnt++;
      end
    end
    return r;
  endfunction

  function automatic logic [HW-1:0] ham_syn(input logic [DW-1:0] d);
    logic [HW-1:0] s;
    s = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) s = s ^ data_pos(i);
    return s;
  endfunction

  function automatic logic [CW-1:0] ecc_encode(input logic [DW-1:0] d);
    logic [HW-1:0] c;
    c = ham_syn(d);
    return {^{c, d}, c, d};
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_rmw_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);
  assign code_o = ecc_encode(data_i);
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_rmw_pkg::*;
(
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] data_o,
  output logic          double_o
);
  logic [HW-1:0] syn;
  logic          par;
  logic [CW-1:0] fixed;
  logic          hit;
  logic          single;

  assign syn = ham_syn(code_i[DW-1:0]) ^ code_i[DW+HW-1:DW];
  assign par = ^code_i;

  always_comb begin
    fixed    = code_i;
    hit      = 1'b0;
    single   = 1'b0;
    double_o = 1'b0;
    if (syn != '0 || par) begin
      if (!par) begin
        double_o = 1'b1;
      end else if (syn == '0) begin
        fixed[CW-1] = ~fixed[CW-1];
        hit = 1'b1;
      end else begin
        for (int k = 0; k < HW; k++)
          if (syn == HW'(1 << k)) begin
            fixed[DW+k] = ~fixed[DW+k];
            hit = 1'b1;
          end
        for (int i = 0; i < DW; i++)
          if (syn == data_pos(i)) begin
            fixed[i] = ~fixed[i];
            hit = 1'b1;
          end
      end
      single   = par && hit;
      double_o = !single;
    end
    data_o = fixed[DW-1:0];
    // R3
    data_flip_chk: assert ($countones(data_o ^ code_i[DW-1:0]) <= 1);
  end
endmodule

// File: rtl/ecc_word_ram.sv
module ecc_word_ram #(
  parameter int AW = 6,
  parameter int W  = 39
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecc_rmw_ram.sv
module ecc_rmw_ram
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W+1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_error,
  input  logic              err_clr,
  output logic              err_flag
);
  localparam int BA = ADDR_W + 2;

  logic              req_fire, req_full;
  logic [NB-1:0]     be_req;
  logic              s1_valid, s1_write, s1_partial;
  logic [ADDR_W-1:0] s1_addr;
  logic [NB-1:0]     s1_be;
  logic [DW-1:0]     s1_wdata;
  logic [CW-1:0]     rd_code, wr_code;
  logic [DW-1:0]     dec_data, merged, enc_in;
  logic              dec_double, ram_we, err_set;
  logic [ADDR_W-1:0] ram_waddr;

  assign req_ready = !(s1_valid && s1_partial);
  assign req_fire  = req_valid && req_ready;
  assign req_full  = req_size[1];

  always_comb begin
    case (req_size)
      2'd0:    be_req = NB'(1) << req_addr[1:0];
      2'd1:    be_req = req_addr[1] ? 4'b1100 : 4'b0011;
      default: be_req = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_write   <= 1'b0;
      s1_partial <= 1'b0;
    end else begin
      s1_valid   <= req_fire;
      s1_write   <= req_write;
      s1_partial <= req_write && !req_full;
    end
    s1_addr  <= req_addr[BA-1:2];
    s1_be    <= be_req;
    s1_wdata <= req_wdata;
  end

  ecc_word_ram #(.AW(ADDR_W), .W(CW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (wr_code),
    .raddr (req_addr[BA-1:2]),
    .rdata (rd_code)
  );

  ecc_decoder u_dec (
    .code_i   (rd_code),
    .data_o   (dec_data),
    .double_o (dec_double)
  );

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign merged[8*l +: 8] = s1_be[l] ? s1_wdata[8*l +: 8] : dec_data[8*l +: 8];
  end

  logic rmw_commit;
  assign rmw_commit = s1_valid && s1_partial;
  assign enc_in    = rmw_commit ? merged : req_wdata;
  assign ram_waddr = rmw_commit ? s1_addr : req_addr[BA-1:2];
  assign ram_we    = (rmw_commit && !dec_double) ||
                     (req_fire && req_write && req_full);

  ecc_encoder u_enc (
    .data_i (enc_in),
    .code_o (wr_code)
  );

  assign err_set = s1_valid && (!s1_write || s1_partial) && dec_double;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
      err_flag  <= 1'b0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_error <= err_set;
      rsp_rdata <= (s1_valid && !s1_write) ? dec_data : '0;
      if (err_set)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> ##1 rsp_valid);
  // R6
  partial_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (req_fire && req_write && !req_full) |=> !req_ready);
  // R9
  read_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (req_fire && !req_write) |=> req_ready);
  // R4
  err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> (rsp_valid && err_flag));
  // R5
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !err_set) |=> !err_flag);
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    err_set |=> err_flag);
  // R8
  no_store_chk: assert property (@(posedge clk) disable iff (rst)
    (rmw_commit && dec_double) |-> !ram_we);
endmodule

// File: tb/ecc_rmw_ram_test.sv
module ecc_rmw_ram_test;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, err_clr = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_error, err_flag;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecc_rmw_ram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_error(rsp_error), .err_clr(err_clr), .err_flag(err_flag)
  );

  typedef struct packed {
    logic        w;
    logic [1:0]  sz;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b1, 2'd2, 8'h00, 32'h11223344, 32'h0},
    '{1'b1, 2'd2, 8'h04, 32'hA5A50F0F, 32'h0},
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'h11223344},
    '{1'b1, 2'd0, 8'h06, 32'h00CC0000, 32'h0},
    '{1'b0, 2'd2, 8'h04, 32'h0,        32'hA5CC0F0F},
    '{1'b1, 2'd1, 8'h02, 32'hBEEF0000, 32'h0},
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'hBEEF3344},
    '{1'b1, 2'd0, 8'h03, 32'h77000000, 32'h0},
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'h77EF3344},
    '{1'b1, 2'd1, 8'h04, 32'h00001234, 32'h0},
    '{1'b0, 2'd2, 8'h04, 32'h0,        32'hA5CC1234}
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic flip(input int w, input int b);
    uut.u_ram.mem[w][b] = ~uut.u_ram.mem[w][b];
  endtask

  task automatic xfer(input bit w, input logic [1:0] sz, input logic [7:0] a,
                      input logic [31:0] d, input bit clr_mid,
                      output logic [31:0] rd, output bit er, output bit stalled);
    bit early;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    stalled = !req_ready;
    early   = rsp_valid;
    err_clr = clr_mid;
    @(negedge clk);
    err_clr = 1'b0;
    rd = rsp_rdata;
    er = rsp_error;
    chk(!early && rsp_valid, "R2 response timing", {30'd0, early, rsp_valid}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit er, st;
    int bits [4] = '{0, 17, 33, 38};

    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!rsp_valid && !rsp_error && !err_flag && req_ready, "R1 in reset",
        {28'd0, rsp_valid, rsp_error, err_flag, req_ready}, 32'h1);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && !rsp_error && !err_flag && req_ready, "R1 after reset",
        {28'd0, rsp_valid, rsp_error, err_flag, req_ready}, 32'h1);

    // Vector table: R2 full access, R6 lane merging
    for (int i = 0; i < 11; i++) begin
      xfer(VECS[i].w, VECS[i].sz, VECS[i].a, VECS[i].d, 1'b0, rd, er, st);
      chk(rd == VECS[i].exp && !er, (VECS[i].w && !VECS[i].sz[1]) ? "R6 merge" : "R2 data",
          rd, VECS[i].exp);
      chk(st == (VECS[i].w && !VECS[i].sz[1]), "R6 ready stall", {31'd0, st},
          {31'd0, VECS[i].w && !VECS[i].sz[1]});
    end

    // R3 single flips in data, check and parity fields
    foreach (bits[j]) begin
      flip(0, bits[j]);
      xfer(1'b0, 2'd2, 8'h00, 32'h0, 1'b0, rd, er, st);
      chk(rd == 32'h77EF3344 && !er && !err_flag, "R3 single correction", rd, 32'h77EF3344);
      flip(0, bits[j]);
    end

    // R4 double error on read
    flip(0, 3); flip(0, 9);
    xfer(1'b0, 2'd2, 8'h00, 32'h0, 1'b0, rd, er, st);
    chk(er, "R4 error response", {31'd0, er}, 32'h1);
    chk(err_flag, "R4 flag set", {31'd0, err_flag}, 32'h1);
    repeat (3) @(negedge clk);
    chk(err_flag, "R5 flag holds", {31'd0, err_flag}, 32'h1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(!err_flag, "R5 clear", {31'd0, err_flag}, 32'h0);
    // R5 error coinciding with clear wins
    xfer(1'b0, 2'd2, 8'h00, 32'h0, 1'b1, rd, er, st);
    chk(err_flag && er, "R5 set beats clear", {31'd0, err_flag}, 32'h1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;

    // R8 sub-word store into double-error word is cancelled
    xfer(1'b1, 2'd0, 8'h00, 32'h00000055, 1'b0, rd, er, st);
    chk(er && err_flag, "R8 error on partial", {30'd0, er, err_flag}, 32'h3);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    flip(0, 3); flip(0, 9);
    xfer(1'b0, 2'd2, 8'h00, 32'h0, 1'b0, rd, er, st);
    chk(rd == 32'h77EF3344 && !er, "R8 word unchanged", rd, 32'h77EF3344);

    // R7 repair before merge, fresh check bits written
    flip(1, 20);
    xfer(1'b1, 2'd0, 8'h04, 32'h00000099, 1'b0, rd, er, st);
    chk(!er, "R7 no error on repaired store", {31'd0, er}, 32'h0);
    flip(1, 25);
    xfer(1'b0, 2'd2, 8'h04, 32'h0, 1'b0, rd, er, st);
    chk(rd == 32'hA5CC1299 && !er, "R7 repaired merge", rd, 32'hA5CC1299);
    flip(1, 25);

    // R9 back-to-back stream
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_addr = 8'h08;
    req_wdata = 32'hCAFEF00D;
    @(negedge clk);
    chk(req_ready, "R9 ready after word store", {31'd0, req_ready}, 32'h1);
    req_write = 1'b0; req_addr = 8'h08;
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'h0, "R9 store response", rsp_rdata, 32'h0);
    chk(req_ready, "R9 ready after read", {31'd0, req_ready}, 32'h1);
    req_addr = 8'h04;
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'hCAFEF00D, "R9 read after store", rsp_rdata, 32'hCAFEF00D);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'hA5CC1299, "R9 pipelined read", rsp_rdata, 32'hA5CC1299);
    @(negedge clk);
    chk(!rsp_valid, "R2 single-cycle response", {31'd0, rsp_valid}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule